// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer

This block holds three independent 32-bit down-counters that share one peripheral clock and one small register bus. Each channel has a live count, a reload value and a control word. A shared run register has one enable bit per channel. A running channel decrements at its own selected fraction of the clock. When it steps past zero it reloads, latches a sticky underflow flag and, if enabled at that moment, raises its own interrupt line. Software acknowledges the interrupt by writing the flag back to zero.

The bus is a single-cycle select/write-enable port. Writes take effect at the clock edge. Reads are combinational from the address. The register layout is: word 0 is the run register, bit c for channel c. Channel c occupies words 4(c+1) for the count, 4(c+1)+1 for the reload and 4(c+1)+2 for the control word. The control word is built as follows: bits [1:0] select the rate, where 0, 1, 2 and 3 mean divide by 4, 16, 64 and 256. Bit 4 is the interrupt enable and bit 7 is the underflow flag. All other bits read as zero.

Top module: `countdown_timer3`

## Requirements
- R1: The count and reload of every channel read back the last value written. The run register reads back only its low three bits. Unmapped words and unused control bits read zero.
- R2: A channel whose run bit is 0 holds its count indefinitely.
- R3: With control rate code k (bits [1:0]), a running channel steps once every 4^(k+1) clock cycles, so with reload R consecutive underflows are (R+1)·4^(k+1) cycles apart.
- R4: A running channel at count 0 that steps loads its reload value and sets its underflow flag (control bit 7) in the same edge.
- R5: A channel's interrupt rises only if its enable (control bit 4) was 1 when the underflow occurred. Setting the enable later, with the flag already set, does not raise it.
- R6: A control write with bit 7 at 0 while the flag is 1 clears the flag and drops that channel's interrupt on the same edge.
- R7: After reset every count and every reload is 0xFFFFFFFF, every control word and the run register are 0, and all interrupts are low.
- R8: The flag is sticky: writing 1 to bit 7 never sets it, and a hardware underflow in the same edge as a clearing write leaves it set.
- R9: Each channel drives its own interrupt output (irq bit c for channel c); an underflow on one channel leaves the other lines unchanged.
- R10: A bus write to a count register wins over a decrement or reload in the same edge, and suppresses that underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 3 | Per-channel interrupt requests |

## Verification
A write lands on the clock edge that follows its presentation. The bench therefore reads count, flag and interrupt state one time-step after that edge and not at it. An underflow updates the count, the flag and the interrupt on the same edge. So when an interrupt is first seen high, the count is read in that same sample and must equal the reload. Underflow spacing is measured by a cycle counter sampled at the same phase at both events. This makes the expected interval exactly (R+1)·4^(k+1) for every channel and rate. The write-priority test holds the write on consecutive edges and checks the count after each one, so a cycle where a prescaler tick coincides with the write is always covered.

// File: rtl/timer3_pkg.sv
// Shared control-word layout and register selector codes for the timer unit.
package timer3_pkg;
    localparam int CTL_W    = 8;  // width of a control word as stored and read
    localparam int IE_BIT   = 4;  // interrupt enable
    localparam int FLAG_BIT = 7;  // sticky underflow flag

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/timer3_prescaler.sv
// Free-running prescaler. It gives one single-cycle tick per rate: rate k
// pulses once every 2^(STEP*(k+1)) cycles. It assumes every channel shares
// this one counter, so the channel phases are aligned.
module timer3_prescaler #(
    parameter int STEP  = 2,
    parameter int NRATE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [NRATE-1:0] tick
);
    localparam int PRE_W = STEP * NRATE;

    logic [PRE_W-1:0] pre_q;

    // advance the shared divider every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // a tick fires when the low bits for that rate are all ones
    for (genvar k = 0; k < NRATE; k++) begin : g_tick
        assign tick[k] = &pre_q[STEP*(k+1)-1:0];
    end
endmodule

// File: rtl/timer3_decode.sv
// Address decoder. It turns a bus access into per-register write strobes
// and a read selection. It assumes word 0 is the run register and channel
// c sits at word group c+1, with the register index in addr[1:0].
module timer3_decode
    import timer3_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              start_hit,
    output logic              start_wr,
    output logic [NUM_CH-1:0] ch_hit,
    output logic [NUM_CH-1:0] cnt_wr,
    output logic [NUM_CH-1:0] rld_wr,
    output logic [NUM_CH-1:0] ctl_wr,
    output reg_sel_e          reg_sel
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;

    assign idx       = bus_addr[ADDR_W-1:2];
    assign reg_sel   = reg_sel_e'(bus_addr[1:0]);
    assign start_hit = bus_sel && (idx == '0) && (reg_sel == SEL_COUNT);
    assign start_wr  = start_hit && bus_we;

    // one decode slice per channel
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ch_hit[c] = bus_sel && (idx == IDX_W'(c + 1)) && (reg_sel != SEL_NONE);
        assign cnt_wr[c] = ch_hit[c] && bus_we && (reg_sel == SEL_COUNT);
        assign rld_wr[c] = ch_hit[c] && bus_we && (reg_sel == SEL_RELOAD);
        assign ctl_wr[c] = ch_hit[c] && bus_we && (reg_sel == SEL_CTRL);
    end
endmodule

// File: rtl/timer3_channel.sv
// One timer channel: count, reload, control, sticky flag and interrupt.
// It assumes the tick inputs are single-cycle pulses and that a bus write
// to the count outranks any decrement or reload on the same edge.
module timer3_channel
    import timer3_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int NRATE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NRATE-1:0] tick,
    input  logic             run,
    input  logic             cnt_wr,
    input  logic             rld_wr,
    input  logic             ctl_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload,
    output logic [CTL_W-1:0] ctl_rd,
    output logic             dec,
    output logic             irq
);
    localparam int RATE_W = $clog2(NRATE);

    logic [CNT_W-1:0]  count_q, reload_q;
    logic [RATE_W-1:0] rate_q;
    logic              ie_q, flag_q, pend_q;
    logic              uf, flag_clr, ack;

    assign dec      = run && tick[rate_q];
    assign uf       = dec && !cnt_wr && (count_q == '0);
    assign flag_clr = ctl_wr && !wdata[FLAG_BIT];
    assign ack      = flag_clr && flag_q;

    // count: bus write first, then reload on underflow, else decrement
    always_ff @(posedge clk) begin
        if (!rst_n)            count_q <= '1;
        else if (cnt_wr)       count_q <= wdata;
        else if (uf)           count_q <= reload_q;
        else if (dec)          count_q <= count_q - 1'b1;
    end

    // reload value, written only by the bus
    always_ff @(posedge clk) begin
        if (!rst_n)      reload_q <= '1;
        else if (rld_wr) reload_q <= wdata;
    end

    // rate and enable fields of the control word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= '0;
            ie_q   <= 1'b0;
        end else if (ctl_wr) begin
            rate_q <= wdata[RATE_W-1:0];
            ie_q   <= wdata[IE_BIT];
        end
    end

    // sticky flag and interrupt pending: a hardware set beats a software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            flag_q <= uf || (flag_q && !flag_clr);
            pend_q <= (uf && ie_q) || (pend_q && !ack);
        end
    end

    // assemble the readable control word
    always_comb begin
        ctl_rd             = '0;
        ctl_rd[RATE_W-1:0] = rate_q;
        ctl_rd[IE_BIT]     = ie_q;
        ctl_rd[FLAG_BIT]   = flag_q;
    end

    assign count  = count_q;
    assign reload = reload_q;
    assign irq    = pend_q;
endmodule

// File: rtl/countdown_timer3.sv
// Top of the three-channel timer. It joins the shared prescaler, the
// address decoder, the run register and one channel per timer, and it
// muxes the read data. Reads are combinational; writes land on the edge.
module countdown_timer3
    import timer3_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32,
    parameter int STEP   = 2,
    parameter int NRATE  = 4,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NRATE-1:0]             tick;
    logic                         start_hit, start_wr;
    logic [NUM_CH-1:0]            ch_hit, cnt_wr, rld_wr, ctl_wr, dec, flag_all;
    reg_sel_e                     reg_sel;
    logic [NUM_CH-1:0]            run_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_all, rld_all;
    logic [NUM_CH-1:0][CTL_W-1:0] ctl_all;

    timer3_prescaler #(.STEP(STEP), .NRATE(NRATE)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    timer3_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .start_hit(start_hit), .start_wr(start_wr), .ch_hit(ch_hit),
        .cnt_wr(cnt_wr), .rld_wr(rld_wr), .ctl_wr(ctl_wr), .reg_sel(reg_sel)
    );

    // shared run register, one bit per channel
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (start_wr) run_q <= bus_wdata[NUM_CH-1:0];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        timer3_channel #(.CNT_W(CNT_W), .NRATE(NRATE)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .run(run_q[c]),
            .cnt_wr(cnt_wr[c]), .rld_wr(rld_wr[c]), .ctl_wr(ctl_wr[c]),
            .wdata(bus_wdata), .count(cnt_all[c]), .reload(rld_all[c]),
            .ctl_rd(ctl_all[c]), .dec(dec[c]), .irq(irq[c])
        );
        assign flag_all[c] = ctl_all[c][FLAG_BIT];
    end

    // read mux: run register or the addressed channel register, else zero
    always_comb begin
        bus_rdata = '0;
        if (start_hit) bus_rdata = CNT_W'(run_q);
        for (int c = 0; c < NUM_CH; c++) begin
            if (ch_hit[c]) begin
                case (reg_sel)
                    SEL_COUNT:  bus_rdata = cnt_all[c];
                    SEL_RELOAD: bus_rdata = rld_all[c];
                    SEL_CTRL:   bus_rdata = CNT_W'(ctl_all[c]);
                    default:    bus_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/timer3_checker.sv
// Property checker for the timer unit, bound to the top module.
module timer3_checker #(
    parameter int NUM_CH = 3,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [CNT_W-1:0]             wdata,
    input logic [NUM_CH-1:0]            run,
    input logic [NUM_CH-1:0]            cnt_wr,
    input logic [NUM_CH-1:0]            ctl_wr,
    input logic [NUM_CH-1:0]            dec,
    input logic [NUM_CH-1:0]            flag,
    input logic [NUM_CH-1:0]            irq,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] rld
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R2: a stopped, unwritten channel keeps its count
        a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!run[c] && !cnt_wr[c]) |=> (cnt[c] == $past(cnt[c])));

        // R4: a step from zero reloads and sets the flag
        a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
            (dec[c] && !cnt_wr[c] && cnt[c] == '0) |=> (cnt[c] == $past(rld[c]) && flag[c]));

        // R5: an interrupt never stands without its flag
        a_r5_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
            irq[c] |-> flag[c]);

        // R6: the interrupt only drops after a control write
        a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(irq[c]) |-> $past(ctl_wr[c]));

        // R8: the flag only falls after a control write carrying a zero flag
        a_r8_flag_fall: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag[c]) |-> $past(ctl_wr[c] && !wdata[timer3_pkg::FLAG_BIT]));

        // R10: a count write always lands
        a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_wr[c] |=> (cnt[c] == $past(wdata)));
    end
endmodule

bind countdown_timer3 timer3_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata), .run(run_q),
    .cnt_wr(cnt_wr), .ctl_wr(ctl_wr), .dec(dec), .flag(flag_all),
    .irq(irq), .cnt(cnt_all), .rld(rld_all)
);

// File: tb/tb_countdown_timer3.sv
// Self-checking bench for the three-channel timer.
module tb_countdown_timer3;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;
    int          checks = 0, fails = 0;
    int          cyc = 0;

    countdown_timer3 dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [3:0] a_cnt(int c); return 4'(4 * (c + 1));     endfunction
    function automatic logic [3:0] a_rld(int c); return 4'(4 * (c + 1) + 1); endfunction
    function automatic logic [3:0] a_ctl(int c); return 4'(4 * (c + 1) + 2); endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_irq(int c, int limit, output int at, output bit seen);
        seen = 0; at = 0;
        for (int n = 0; n < limit && !seen; n++) begin
            @(negedge clk);
            if (irq[c]) begin seen = 1; at = cyc; end
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(20 * 190000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int          t1, t2;
        bit          seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset values
        for (int c = 0; c < 3; c++) begin
            rd(a_cnt(c), v); check("R7 count", v, 32'hFFFF_FFFF);
            rd(a_rld(c), v); check("R7 reload", v, 32'hFFFF_FFFF);
            rd(a_ctl(c), v); check("R7 control", v, 32'h0);
        end
        rd(4'h0, v); check("R7 run", v, 32'h0);
        check("R7 irq", {29'h0, irq}, 32'h0);

        // R1: register access
        wr(a_rld(1), 32'h1234_5678); rd(a_rld(1), v); check("R1 reload", v, 32'h1234_5678);
        wr(a_cnt(2), 32'hCAFE_0001); rd(a_cnt(2), v); check("R1 count", v, 32'hCAFE_0001);
        wr(4'h0, 32'hFFFF_FFF8);     rd(4'h0, v);     check("R1 run mask", v, 32'h0);
        wr(a_ctl(0), 32'hFFFF_FF63); rd(a_ctl(0), v); check("R1 control bits", v, 32'h3);
        rd(4'h3, v); check("R1 unmapped", v, 32'h0);
        rd(4'h7, v); check("R1 unmapped ch", v, 32'h0);
        wr(a_ctl(0), 32'h0);

        // R2: stopped channel holds
        wr(a_cnt(0), 32'd100);
        repeat (600) @(negedge clk);
        rd(a_cnt(0), v); check("R2 hold", v, 32'd100);

        // R3/R4/R6/R9: period sweep over every channel and rate, reload 5
        for (int c = 0; c < 3; c++) begin
            for (int k = 0; k < 4; k++) begin
                int per;
                per = 6 * (4 << (2 * k));
                wr(4'h0, 32'h0);
                wr(a_rld(c), 32'd5);
                wr(a_cnt(c), 32'd5);
                wr(a_ctl(c), 32'h10 | k);
                wr(4'h0, 32'(1 << c));
                wait_irq(c, 3 * per, t1, seen);
                check("R3 first irq", {31'h0, seen}, 32'h1);
                bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a_cnt(c);
                #1 v = bus_rdata; bus_sel = 1'b0;
                check("R4 reload at underflow", v, 32'd5);
                check("R9 other irqs", {29'h0, irq & ~3'(1 << c)}, 32'h0);
                wr(a_ctl(c), 32'h10 | k);
                check("R6 ack drops irq", {31'h0, irq[c]}, 32'h0);
                wait_irq(c, 3 * per, t2, seen);
                check("R3 period", 32'(t2 - t1), 32'(per));
                wr(4'h0, 32'h0);
                wr(a_ctl(c), 32'h0);
            end
        end

        // R5/R8: underflow with enable off, late enable, ack, sticky write
        wr(a_rld(1), 32'd2);
        wr(a_cnt(1), 32'd2);
        wr(a_ctl(1), 32'h0);
        wr(4'h0, 32'h2);
        repeat (40) @(negedge clk);
        wr(4'h0, 32'h0);
        rd(a_ctl(1), v); check("R5 flag without enable", v, 32'h80);
        check("R5 no irq without enable", {31'h0, irq[1]}, 32'h0);
        wr(a_ctl(1), 32'h90);
        repeat (20) @(negedge clk);
        check("R5 late enable no irq", {31'h0, irq[1]}, 32'h0);
        rd(a_ctl(1), v); check("R8 flag kept by writing 1", v, 32'h90);
        wr(a_ctl(1), 32'h10);
        rd(a_ctl(1), v); check("R6 flag cleared", v, 32'h10);
        wr(a_ctl(1), 32'h90);
        rd(a_ctl(1), v); check("R8 writing 1 does not set", v, 32'h10);

        // R10: back-to-back count writes on a running /4 channel
        wr(a_rld(2), 32'd9);
        wr(a_ctl(2), 32'h10);
        wr(4'h0, 32'h4);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a_cnt(2); bus_wdata = 32'd0;
        for (int n = 0; n < 8; n++) begin
            @(posedge clk); #1;
            check("R10 write wins", bus_rdata, 32'd0);
            check("R10 no irq", {31'h0, irq[2]}, 32'h0);
        end
        bus_sel = 1'b0; bus_we = 1'b0;
        wr(4'h0, 32'h0);
        rd(a_ctl(2), v); check("R10 underflow suppressed", v, 32'h10);

        finish_run();
    end
endmodule